// File: doc/BRIEF.md
# Ethernet MAC Flow Control Unit

This unit handles link-level flow control for a small Ethernet MAC. Software sets its behaviour through one 8-bit control/status register. The unit raises pause-frame transmit requests with a pause time of either 0000h or FFFFh. A request comes from one of two self-clearing command bits, or it comes automatically when the receive-buffer fill level crosses a pair of water marks. The transmit side holds the requested pause time stable and acknowledges each frame once it is sent.

In half duplex the unit raises a jam request when a packet arrives and the receive buffer is too full. Two modes decide which packets count: any arriving packet, or only packets whose destination address matches. The unit also tracks received pause frames. It keeps a sticky flag that clears on read and a live flag that follows the pause currently in effect. When flow control is enabled, the live flag stops the transmitter. Building the frames and driving the jam pattern are handled elsewhere.

Top module: `eth_flow_ctl`

## Requirements
- R1: After reset every register bit reads 0, and `pause_req`, `jam_req` and `tx_stop` are low.
- R2: The register layout is bit 7 = pause-zero command, bit 6 = pause-max command, bit 5 = threshold enable, bit 4 = back-pressure on any packet, bit 3 = back-pressure on address match, bit 2 = sticky RX-pause flag, bit 1 = live RX-pause flag, bit 0 = flow-control enable. Bits 5, 4, 3 and 0 store the written value. Writes have no effect on bits 2 and 1. Writing 0 to bit 7 or bit 6 leaves it unchanged.
- R3: Writing 1 to bit 7 raises `pause_req` with `pause_time` = 0000h two cycles after the write. The request holds until `pause_sent`, and bit 7 reads 0 after that acknowledge.
- R4: Writing 1 to bit 6 works the same way with `pause_time` = FFFFh, and bit 6 clears on its acknowledge.
- R5: Only one request is outstanding at a time. The order of service is bit 7, then bit 6, then a threshold request.
- R6: With bit 5 set, a fill level rising above `hi_mark` requests one FFFFh pause. No further request follows until the fill level drops below `lo_mark`, which requests one 0000h pause.
- R7: With bit 5 clear, crossing a water mark requests no pause.
- R8: In half duplex with bit 4 set, `jam_req` is high exactly while `pkt_start` is high and `rx_fill` > `bp_mark`.
- R9: In half duplex with only bit 3 set, `jam_req` additionally needs `da_match`.
- R10: In full duplex `jam_req` stays low whatever bits 4 and 3 hold.
- R11: `pause_rx` sets bit 2. A read returns the bit and then clears it, unless `pause_rx` arrives in the same cycle as the read, in which case the bit stays set.
- R12: Bit 1 is set by `pause_rx` and cleared by `pause_done`. `tx_stop` is high exactly when bits 1 and 0 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe (clears the sticky flag) |
| reg_rdata | output | 8 | Register value |
| rx_fill | input | FILL_W | Receive buffer fill level |
| hi_mark | input | FILL_W | Pause high-water mark |
| lo_mark | input | FILL_W | Pause low-water mark |
| bp_mark | input | FILL_W | Back-pressure high-water mark |
| full_duplex | input | 1 | 1 = full duplex link |
| pkt_start | input | 1 | Packet arrival strobe |
| da_match | input | 1 | Destination address matched |
| pause_rx | input | 1 | Pause frame received pulse |
| pause_done | input | 1 | Received pause expired pulse |
| pause_sent | input | 1 | Transmit side sent the requested pause frame |
| pause_req | output | 1 | Pause frame transmit request |
| pause_time | output | 16 | Pause time for the request |
| jam_req | output | 1 | Back-pressure jam request |
| tx_stop | output | 1 | Stop the transmitter |

## Verification
The jam decision is tried against a table of patterns. Each row changes one factor at a time: duplex mode, the mode bits, packet presence, the address match, and a fill level on either side of `bp_mark`, including the level equal to it. Together the rows separate the any-packet mode from the address-match mode and show the full-duplex override. The pause paths are driven with both commands set together, which shows the service order. They are also driven with a fill level that rises, sits still, wanders between the marks and then falls, which shows the hysteresis. The received-pause tests collide a read with a new pause frame, and they toggle flow-control enable, to separate the sticky flag from the live one.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int PT_W = 16;
  localparam logic [PT_W-1:0] PT_ZERO = '0;
  localparam logic [PT_W-1:0] PT_MAX  = '1;

  // register bit positions (software-visible layout)
  localparam int B_CMD_ZERO = 7;
  localparam int B_CMD_MAX  = 6;
  localparam int B_THR_EN   = 5;
  localparam int B_BP_ANY   = 4;
  localparam int B_BP_DA    = 3;
  localparam int B_RXP_STKY = 2;
  localparam int B_RXP_LIVE = 1;
  localparam int B_FC_EN    = 0;

  typedef enum logic [1:0] {SRC_NONE, SRC_ZERO, SRC_MAX, SRC_THR} src_t;

  function automatic logic fc_over(input logic [31:0] lvl, input logic [31:0] mark);
    return lvl > mark;
  endfunction

  function automatic logic fc_under(input logic [31:0] lvl, input logic [31:0] mark);
    return lvl < mark;
  endfunction

  function automatic logic fc_jam(input logic hdx, input logic pkt, input logic over,
                                  input logic any_m, input logic da_m, input logic hit);
    return hdx && pkt && over && (any_m || (da_m && hit));
  endfunction
endpackage

// File: rtl/fc_regs.sv
module fc_regs
  import fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       rd,
  output logic [7:0] rdata,
  input  logic       pause_rx,
  input  logic       pause_done,
  input  logic       ack_zero,
  input  logic       ack_max,
  output logic       cmd_zero,
  output logic       cmd_max,
  output logic       thr_en,
  output logic       bp_any,
  output logic       bp_da,
  output logic       fc_en,
  output logic       rxp_live
);
  logic rxp_stky;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_zero <= 1'b0;
      cmd_max  <= 1'b0;
      thr_en   <= 1'b0;
      bp_any   <= 1'b0;
      bp_da    <= 1'b0;
      fc_en    <= 1'b0;
      rxp_stky <= 1'b0;
      rxp_live <= 1'b0;
    end else begin
      cmd_zero <= (cmd_zero && !ack_zero) || (wr && wdata[B_CMD_ZERO]);
      cmd_max  <= (cmd_max && !ack_max) || (wr && wdata[B_CMD_MAX]);
      if (wr) begin
        thr_en <= wdata[B_THR_EN];
        bp_any <= wdata[B_BP_ANY];
        bp_da  <= wdata[B_BP_DA];
        fc_en  <= wdata[B_FC_EN];
      end
      rxp_stky <= pause_rx || (rxp_stky && !rd);
      rxp_live <= pause_rx || (rxp_live && !pause_done);
    end
  end

  always_comb begin
    rdata = '0;
    rdata[B_CMD_ZERO] = cmd_zero;
    rdata[B_CMD_MAX]  = cmd_max;
    rdata[B_THR_EN]   = thr_en;
    rdata[B_BP_ANY]   = bp_any;
    rdata[B_BP_DA]    = bp_da;
    rdata[B_RXP_STKY] = rxp_stky;
    rdata[B_RXP_LIVE] = rxp_live;
    rdata[B_FC_EN]    = fc_en;
  end

  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !pause_rx) |=> !rxp_stky);
  assert_rx_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pause_rx |=> rxp_stky && rxp_live);
  assert_live_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxp_live) |-> $past(pause_rx));
endmodule

// File: rtl/fc_thresh.sv
module fc_thresh
  import fc_pkg::*;
#(
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [FILL_W-1:0] fill,
  input  logic [FILL_W-1:0] hi_mark,
  input  logic [FILL_W-1:0] lo_mark,
  input  logic              taken,
  output logic              pend,
  output logic              pend_max
);
  logic above;
  logic cross_up, cross_dn;

  assign cross_up = enable && !above && fc_over(32'(fill), 32'(hi_mark));
  assign cross_dn = enable && above && fc_under(32'(fill), 32'(lo_mark));

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      above    <= 1'b0;
      pend     <= 1'b0;
      pend_max <= 1'b0;
    end else begin
      if (cross_up) above <= 1'b1;
      else if (cross_dn) above <= 1'b0;
      if (cross_up || cross_dn) begin
        pend     <= 1'b1;
        pend_max <= cross_up;
      end else if (taken) begin
        pend <= 1'b0;
      end
    end
  end

  assert_up_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(above) |-> $past(enable && fill > hi_mark));
  assert_no_pend_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pend);
endmodule

// File: rtl/fc_pause_arb.sv
module fc_pause_arb
  import fc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_zero,
  input  logic            cmd_max,
  input  logic            thr_pend,
  input  logic            thr_max,
  input  logic            sent,
  output logic            req,
  output logic [PT_W-1:0] ptime,
  output logic            ack_zero,
  output logic            ack_max,
  output logic            thr_taken
);
  src_t src;
  logic grant;

  assign grant     = !req && (cmd_zero || cmd_max || thr_pend);
  assign thr_taken = grant && !cmd_zero && !cmd_max;
  assign ack_zero  = req && sent && (src == SRC_ZERO);
  assign ack_max   = req && sent && (src == SRC_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req   <= 1'b0;
      ptime <= PT_ZERO;
      src   <= SRC_NONE;
    end else if (grant) begin
      req <= 1'b1;
      if (cmd_zero) begin
        ptime <= PT_ZERO;
        src   <= SRC_ZERO;
      end else if (cmd_max) begin
        ptime <= PT_MAX;
        src   <= SRC_MAX;
      end else begin
        ptime <= thr_max ? PT_MAX : PT_ZERO;
        src   <= SRC_THR;
      end
    end else if (req && sent) begin
      req <= 1'b0;
      src <= SRC_NONE;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !sent) |=> req && $stable(ptime));
  assert_zero_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && cmd_zero) |=> ptime == PT_ZERO);
  assert_one_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_zero, ack_max, thr_taken}));
endmodule

// File: rtl/fc_backpressure.sv
module fc_backpressure
  import fc_pkg::*;
#(
  parameter int FILL_W = 8
) (
  input  logic              full_duplex,
  input  logic              pkt_start,
  input  logic              da_match,
  input  logic              bp_any,
  input  logic              bp_da,
  input  logic [FILL_W-1:0] fill,
  input  logic [FILL_W-1:0] bp_mark,
  output logic              jam
);
  logic over;
  assign over = fc_over(32'(fill), 32'(bp_mark));
  assign jam  = fc_jam(!full_duplex, pkt_start, over, bp_any, bp_da, da_match);

  always_comb begin
    assert_fdx_quiet_R10: assert (!(full_duplex && jam));
  end
endmodule

// File: rtl/eth_flow_ctl.sv
module eth_flow_ctl
  import fc_pkg::*;
#(
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] hi_mark,
  input  logic [FILL_W-1:0] lo_mark,
  input  logic [FILL_W-1:0] bp_mark,
  input  logic              full_duplex,
  input  logic              pkt_start,
  input  logic              da_match,
  input  logic              pause_rx,
  input  logic              pause_done,
  input  logic              pause_sent,
  output logic              pause_req,
  output logic [15:0]       pause_time,
  output logic              jam_req,
  output logic              tx_stop
);
  logic cmd_zero, cmd_max, thr_en, bp_any, bp_da, fc_en, rxp_live;
  logic ack_zero, ack_max, thr_taken, thr_pend, thr_max;
  logic [PT_W-1:0] ptime;

  fc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .rd(reg_rd),
    .rdata(reg_rdata), .pause_rx(pause_rx), .pause_done(pause_done),
    .ack_zero(ack_zero), .ack_max(ack_max), .cmd_zero(cmd_zero),
    .cmd_max(cmd_max), .thr_en(thr_en), .bp_any(bp_any), .bp_da(bp_da),
    .fc_en(fc_en), .rxp_live(rxp_live)
  );

  fc_thresh #(.FILL_W(FILL_W)) u_thresh (
    .clk(clk), .rst_n(rst_n), .enable(thr_en), .fill(rx_fill),
    .hi_mark(hi_mark), .lo_mark(lo_mark), .taken(thr_taken),
    .pend(thr_pend), .pend_max(thr_max)
  );

  fc_pause_arb u_arb (
    .clk(clk), .rst_n(rst_n), .cmd_zero(cmd_zero), .cmd_max(cmd_max),
    .thr_pend(thr_pend), .thr_max(thr_max), .sent(pause_sent),
    .req(pause_req), .ptime(ptime), .ack_zero(ack_zero), .ack_max(ack_max),
    .thr_taken(thr_taken)
  );

  fc_backpressure #(.FILL_W(FILL_W)) u_bp (
    .full_duplex(full_duplex), .pkt_start(pkt_start), .da_match(da_match),
    .bp_any(bp_any), .bp_da(bp_da), .fill(rx_fill), .bp_mark(bp_mark),
    .jam(jam_req)
  );

  assign pause_time = 16'(ptime);
  assign tx_stop    = fc_en && rxp_live;

  assert_stop_needs_pause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop |-> reg_rdata[B_RXP_LIVE] && reg_rdata[B_FC_EN]);
  assert_cmd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && pause_sent && pause_time == 16'h0000 && cmd_zero && !(reg_wr && reg_wdata[7]))
      |=> !reg_rdata[B_CMD_ZERO]);
endmodule

// File: tb/eth_flow_ctl_bench.sv
`timescale 1ns/1ps
module eth_flow_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [7:0] rx_fill = 0, hi_mark = 200, lo_mark = 50, bp_mark = 150;
  logic full_duplex = 0, pkt_start = 0, da_match = 0;
  logic pause_rx = 0, pause_done = 0, pause_sent = 0;
  logic pause_req, jam_req, tx_stop;
  logic [15:0] pause_time;
  int errors = 0, checks = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  eth_flow_ctl u_eth_flow_ctl (.*);

  // jam table: fdx, any, da, pkt, match, fill[7:0], expected
  localparam logic [13:0] JV [8] = '{
    {1'b0,1'b1,1'b0,1'b1,1'b0,8'd200,1'b1},  // R8 over mark
    {1'b0,1'b1,1'b0,1'b1,1'b0,8'd150,1'b0},  // R8 equal to mark
    {1'b0,1'b1,1'b0,1'b0,1'b0,8'd200,1'b0},  // R8 no packet
    {1'b0,1'b0,1'b1,1'b1,1'b0,8'd200,1'b0},  // R9 no match
    {1'b0,1'b0,1'b1,1'b1,1'b1,8'd200,1'b1},  // R9 match
    {1'b0,1'b0,1'b1,1'b1,1'b1,8'd100,1'b0},  // R9 below mark
    {1'b1,1'b1,1'b1,1'b1,1'b1,8'd255,1'b0},  // R10 full duplex
    {1'b0,1'b0,1'b0,1'b1,1'b1,8'd255,1'b0}   // R8 no mode bit
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); reg_rd = 1; v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic ack();
    @(negedge clk); pause_sent = 1;
    @(negedge clk); pause_sent = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 outputs", {pause_req, jam_req, tx_stop}, 3'b000);
    @(negedge clk); rst_n = 1;

    // jam table walk (R8 R9 R10)
    for (int k = 0; k < 8; k++) begin
      wr({3'b000, JV[k][12], JV[k][11], 3'b000});
      @(negedge clk);
      full_duplex = JV[k][13]; pkt_start = JV[k][10];
      da_match = JV[k][9]; rx_fill = JV[k][8:1];
      #1 chk($sformatf("R8/R9/R10 jam row %0d", k), jam_req, JV[k][0]);
      @(negedge clk); pkt_start = 0; da_match = 0; full_duplex = 0; rx_fill = 0;
    end
    wr(8'h00);

    // R2 write layout, read-only bits ignore writes
    wr(8'h3F); rd(rv);
    chk("R2 stored bits", rv, 8'h39);
    wr(8'h00); rd(rv);
    chk("R2 cleared", rv, 8'h00);

    // R3 pause zero
    wr(8'h80);
    chk("R3 req early", pause_req, 1'b0);
    @(negedge clk);
    chk("R3 req", pause_req, 1'b1);
    chk("R3 time", pause_time, 16'h0000);
    wr(8'h00);
    idle(2);
    chk("R3 hold", pause_req, 1'b1);
    ack();
    rd(rv);
    chk("R3 bit cleared", rv[7], 1'b0);
    chk("R3 req dropped", pause_req, 1'b0);

    // R4 pause max
    wr(8'h40); @(negedge clk);
    chk("R4 req", pause_req, 1'b1);
    chk("R4 time", pause_time, 16'hFFFF);
    ack(); rd(rv);
    chk("R4 bit cleared", rv[6], 1'b0);

    // R5 priority
    wr(8'hC0); @(negedge clk);
    chk("R5 first time", pause_time, 16'h0000);
    ack(); rd(rv);
    chk("R5 bit6 still pending", rv[7:6], 2'b01);
    chk("R5 second time", {pause_req, pause_time}, {1'b1, 16'hFFFF});
    ack(); idle(2);
    chk("R5 idle after both", pause_req, 1'b0);

    // R6 thresholds
    wr(8'h20);
    rx_fill = 100; idle(3);
    chk("R6 between marks", pause_req, 1'b0);
    rx_fill = 210; idle(2);
    chk("R6 up req", {pause_req, pause_time}, {1'b1, 16'hFFFF});
    ack(); idle(4);
    chk("R6 no repeat high", pause_req, 1'b0);
    rx_fill = 100; idle(3);
    rx_fill = 205; idle(3);
    chk("R6 hysteresis", pause_req, 1'b0);
    rx_fill = 40; idle(2);
    chk("R6 down req", {pause_req, pause_time}, {1'b1, 16'h0000});
    ack(); idle(3);
    chk("R6 no repeat low", pause_req, 1'b0);

    // R7 disabled
    wr(8'h00);
    rx_fill = 220; idle(4);
    chk("R7 no req", pause_req, 1'b0);
    rx_fill = 0; idle(4);
    chk("R7 no req low", pause_req, 1'b0);

    // R11 sticky flag
    @(negedge clk); pause_rx = 1;
    @(negedge clk); pause_rx = 0;
    rd(rv);
    chk("R11 sticky set", rv[2:1], 2'b11);
    rd(rv);
    chk("R11 cleared by read", rv[2], 1'b0);
    @(negedge clk); pause_rx = 1; reg_rd = 1;
    @(negedge clk); pause_rx = 0; reg_rd = 0;
    rd(rv);
    chk("R11 set wins", rv[2], 1'b1);

    // R12 live flag and tx_stop
    chk("R12 no stop while disabled", tx_stop, 1'b0);
    wr(8'h01);
    chk("R12 stop", tx_stop, 1'b1);
    @(negedge clk); pause_done = 1;
    @(negedge clk); pause_done = 0;
    chk("R12 released", tx_stop, 1'b0);
    rd(rv);
    chk("R12 live clear", rv[1], 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule